// File: doc/BRIEF.md
# Address-Masked GPIO Controller with Key-Protected Alternate Function

This block is an eight-pin general-purpose I/O port that sits behind a simple word-addressed register bus. The bus covers a 4 KB window: 1024 words, so the word address is 10 bits and byte offset = 4 × word. Any access to the lower quarter of the window reaches the pin data. The low eight bits of the word address act as a per-bit mask for that access, so software can read or update any subset of pins in one transaction without first reading them. A direction register decides which pins the block drives. Only driven pins accept data writes. Pins configured as inputs show their synchronised external level.

Other registers in the window hold the interrupt configuration, the interrupt status and clear, and eight pad-control bytes. The block only stores the pad-control bytes; it does not act on them. The alternate-function selection is protected in two stages. A commit register decides which of its bits a write may change, and the commit register itself can only be written after a 32-bit key has been written to a lock register. A read-only identification area fills the top twelve words of the window.

Input pins pass through a two-stage synchroniser. The synchronised levels feed a per-pin detector that can be set to level, single-edge or both-edge sensing. The masked status bits are combined into one registered interrupt line.

Top module: `amgpio_top`

## Requirements
- R1: A read with word address below 0x100 (byte offset below 0x400) returns the pin data view ANDed with word-address bits [7:0]. Read data and `bus_rvalid` appear in the cycle after the access is accepted.
- R2: A data write changes only those bits of the output latch that are set in both word-address bits [7:0] and the direction register (1 = output). `pin_out` shows the new value one cycle after the write. `pin_oe` mirrors the direction register.
- R3: For a pin whose direction bit is 0, the data view follows `pin_in` after a two-flop synchroniser. For a pin whose direction bit is 1, the data view returns the output latch.
- R4: The direction (byte offset 0x400), sense (0x404), both-edges (0x408), event (0x40C) and mask (0x410) registers are 8-bit read/write. So are the eight pad-control bytes at offsets 0x500 through 0x51C. All of them reset to 0.
- R5: Writing 0x0ACCE551 to offset 0x520 unlocks the block, and writing any other value locks it. A read of 0x520 returns 1 while locked and 0 while unlocked. The block is locked after reset.
- R6: The commit register (0x524) resets to 0xFF and accepts writes only while the block is unlocked.
- R7: A write to the alternate-function register (0x420) changes only the bits that are set in the commit register. `alt_sel` shows that register, which resets to 0.
- R8: Byte offsets 0xFD0 to 0xFFC return one identification byte per word. From the lowest offset upward the bytes are 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R9: A pin with sense 0 sets its raw status bit on an edge of the synchronised level. If its both-edges bit is 1, either edge sets the bit. Otherwise event bit 1 selects rising edges and event bit 0 selects falling edges. A pin with sense 1 sets its raw status bit in every cycle in which the level equals its event bit.
- R10: Raw status (0x414) bits stay set until they are cleared by writing 1s to offset 0x41C. A set condition in the same cycle wins over the clear.
- R11: Masked status (0x418) equals raw status AND mask. `irq` is the OR of the masked bits, registered. A pin edge appears on `irq` at the fourth rising clock after the pin changes.
- R12: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output latch driven to the pads |
| pin_oe | output | 8 | Output enable per pin |
| alt_sel | output | 8 | Alternate-function selection |
| irq | output | 1 | Combined interrupt |

## Verification
Read data always arrives one cycle after the access. The scoreboard queues each expected word when the read is issued, and the monitor compares it on the first falling edge at which `bus_rvalid` is high. `pin_out`, `pin_oe` and `alt_sel` settle one edge after the write, and the bench samples them on the falling edge after the write task ends. A pin change takes two edges to reach the data view and three edges to set raw status, and `irq` follows at the fourth. The bench waits two full cycles before reading inputs. It samples `irq` after exactly three and after exactly four edges, so a wrong pipeline depth is caught in either direction.

// File: rtl/amgpio_pkg.sv
package amgpio_pkg;

  localparam int BUS_AW = 10;
  localparam int BUS_DW = 32;

  // word addresses (byte offset / 4)
  localparam logic [BUS_AW-1:0] W_DIR    = 10'h100;
  localparam logic [BUS_AW-1:0] W_SENSE  = 10'h101;
  localparam logic [BUS_AW-1:0] W_BOTH   = 10'h102;
  localparam logic [BUS_AW-1:0] W_EVENT  = 10'h103;
  localparam logic [BUS_AW-1:0] W_MASK   = 10'h104;
  localparam logic [BUS_AW-1:0] W_RAW    = 10'h105;
  localparam logic [BUS_AW-1:0] W_MIS    = 10'h106;
  localparam logic [BUS_AW-1:0] W_CLR    = 10'h107;
  localparam logic [BUS_AW-1:0] W_ALT    = 10'h108;
  localparam logic [BUS_AW-1:0] W_PAD0   = 10'h140;
  localparam logic [BUS_AW-1:0] W_LOCK   = 10'h148;
  localparam logic [BUS_AW-1:0] W_COMMIT = 10'h149;
  localparam logic [BUS_AW-1:0] W_ID0    = 10'h3F4;

  localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h0ACC_E551;

  // Identification byte selected by the low nibble of the word address.
  // The area begins at nibble 4 and ends at nibble 15.
  function automatic logic [7:0] id_byte(input logic [3:0] nib);
    case (nib)
      4'd8:    id_byte = 8'h61;
      4'd10:   id_byte = 8'h18;
      4'd11:   id_byte = 8'h01;
      4'd12:   id_byte = 8'h0D;
      4'd13:   id_byte = 8'hF0;
      4'd14:   id_byte = 8'h05;
      4'd15:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/amgpio_sync.sv
module amgpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/amgpio_irq_detect.sv
module amgpio_irq_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] sense_i,
  input  logic [WIDTH-1:0] both_i,
  input  logic [WIDTH-1:0] event_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic rise, fall, hit, drop;
    assign rise = level_i[i] & ~prev_q[i];
    assign fall = ~level_i[i] & prev_q[i];
    always_comb begin
      if (sense_i[i])     hit = (level_i[i] == event_i[i]);
      else if (both_i[i]) hit = rise | fall;
      else if (event_i[i]) hit = rise;
      else                hit = fall;
    end
    assign drop = clr_en_i & clr_bits_i[i];

    always_ff @(posedge clk) begin
      if (rst)      raw_o[i] <= 1'b0;
      else if (hit) raw_o[i] <= 1'b1;
      else if (drop) raw_o[i] <= 1'b0;
    end

    // R10: status is sticky unless a clear names this bit
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (raw_o[i] && !(clr_en_i && clr_bits_i[i])) |=> raw_o[i]);
    // R9: an edge-sensed bit cannot rise while the level is steady
    assert_edge_only_R9: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[i] && !raw_o[i] && level_i[i] == prev_q[i]) |=> !raw_o[i]);
  end
endmodule

// File: rtl/amgpio_lock.sv
module amgpio_lock #(
  parameter int WIDTH = 8,
  parameter int DW    = 32,
  parameter logic [DW-1:0] KEY = 32'h0ACC_E551
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lock_i,
  input  logic             wr_commit_i,
  input  logic             wr_alt_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             locked_o,
  output logic [WIDTH-1:0] commit_o,
  output logic [WIDTH-1:0] alt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b1;
      commit_o <= '1;
      alt_o    <= '0;
    end else begin
      if (wr_lock_i) locked_o <= (wdata_i != KEY);
      if (wr_commit_i && !locked_o) commit_o <= wdata_i[WIDTH-1:0];
      if (wr_alt_i) alt_o <= (alt_o & ~commit_o) | (wdata_i[WIDTH-1:0] & commit_o);
    end
  end

  // R5/R6: reset leaves the block locked with every commit bit open
  assert_reset_state_R5: assert property (@(posedge clk)
    $past(rst) |-> (locked_o && commit_o == '1));
  // R6: commit is frozen while locked
  assert_commit_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (locked_o && wr_commit_i) |=> $stable(commit_o));
  // R7: bits outside commit never move
  assert_alt_guard_R7: assert property (@(posedge clk) disable iff (rst)
    wr_alt_i |=> ((alt_o ^ $past(alt_o)) & ~$past(commit_o)) == '0);
endmodule

// File: rtl/amgpio_top.sv
module amgpio_top #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PAD_REGS    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [amgpio_pkg::BUS_AW-1:0] bus_addr,
  input  logic [amgpio_pkg::BUS_DW-1:0] bus_wdata,
  output logic [amgpio_pkg::BUS_DW-1:0] bus_rdata,
  output logic                         bus_rvalid,
  input  logic [NPINS-1:0]             pin_in,
  output logic [NPINS-1:0]             pin_out,
  output logic [NPINS-1:0]             pin_oe,
  output logic [NPINS-1:0]             alt_sel,
  output logic                         irq
);
  import amgpio_pkg::*;

  localparam int PAD_IW = $clog2(PAD_REGS);

  logic             wr_en, rd_en, is_data, is_pad, is_id;
  logic [NPINS-1:0] acc_mask, wmask;
  logic [NPINS-1:0] dir_q, sense_q, both_q, event_q, imask_q, out_q;
  logic [NPINS-1:0] pad_q [PAD_REGS];
  logic [NPINS-1:0] pin_sync, data_view, raw, mis, commit, alt;
  logic             locked;
  logic [BUS_DW-1:0] rd_val;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign is_data  = (bus_addr[BUS_AW-1:BUS_AW-2] == 2'b00);
  assign is_pad   = (bus_addr[BUS_AW-1:PAD_IW] == W_PAD0[BUS_AW-1:PAD_IW]);
  assign is_id    = (bus_addr >= W_ID0);
  assign acc_mask = bus_addr[NPINS-1:0];
  assign wmask    = acc_mask & dir_q;

  amgpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(pin_sync)
  );

  assign data_view = (dir_q & out_q) | (~dir_q & pin_sync);

  amgpio_irq_detect #(.WIDTH(NPINS)) u_det (
    .clk(clk), .rst(rst), .level_i(pin_sync),
    .sense_i(sense_q), .both_i(both_q), .event_i(event_q),
    .clr_en_i(wr_en && bus_addr == W_CLR),
    .clr_bits_i(bus_wdata[NPINS-1:0]),
    .raw_o(raw)
  );

  assign mis = raw & imask_q;

  amgpio_lock #(.WIDTH(NPINS), .DW(BUS_DW), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst),
    .wr_lock_i(wr_en && bus_addr == W_LOCK),
    .wr_commit_i(wr_en && bus_addr == W_COMMIT),
    .wr_alt_i(wr_en && bus_addr == W_ALT),
    .wdata_i(bus_wdata),
    .locked_o(locked), .commit_o(commit), .alt_o(alt)
  );

  // configuration and output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      imask_q <= '0;
      out_q   <= '0;
    end else if (wr_en) begin
      if (is_data) out_q <= (out_q & ~wmask) | (bus_wdata[NPINS-1:0] & wmask);
      case (bus_addr)
        W_DIR:   dir_q   <= bus_wdata[NPINS-1:0];
        W_SENSE: sense_q <= bus_wdata[NPINS-1:0];
        W_BOTH:  both_q  <= bus_wdata[NPINS-1:0];
        W_EVENT: event_q <= bus_wdata[NPINS-1:0];
        W_MASK:  imask_q <= bus_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  // pad-control bytes, one register per word
  for (genvar p = 0; p < PAD_REGS; p++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) pad_q[p] <= '0;
      else if (wr_en && is_pad && bus_addr[PAD_IW-1:0] == PAD_IW'(p))
        pad_q[p] <= bus_wdata[NPINS-1:0];
    end
  end

  // read selection
  always_comb begin
    rd_val = '0;
    if (is_data)      rd_val = BUS_DW'(data_view & acc_mask);
    else if (is_id)   rd_val = BUS_DW'(id_byte(bus_addr[3:0]));
    else if (is_pad)  rd_val = BUS_DW'(pad_q[bus_addr[PAD_IW-1:0]]);
    else begin
      case (bus_addr)
        W_DIR:    rd_val = BUS_DW'(dir_q);
        W_SENSE:  rd_val = BUS_DW'(sense_q);
        W_BOTH:   rd_val = BUS_DW'(both_q);
        W_EVENT:  rd_val = BUS_DW'(event_q);
        W_MASK:   rd_val = BUS_DW'(imask_q);
        W_RAW:    rd_val = BUS_DW'(raw);
        W_MIS:    rd_val = BUS_DW'(mis);
        W_ALT:    rd_val = BUS_DW'(alt);
        W_LOCK:   rd_val = BUS_DW'(locked);
        W_COMMIT: rd_val = BUS_DW'(commit);
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_val : '0;
      irq        <= |mis;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign alt_sel = alt;

  // R2: a data write leaves input-direction and unmasked bits alone
  assert_dir_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_data) |=> ((out_q ^ $past(out_q)) & ~$past(dir_q & acc_mask)) == '0);
  // R1: read data is valid exactly one cycle after a read strobe
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> bus_rvalid);
  // R12: nothing but a direction write moves the direction register
  assert_dir_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && bus_addr == W_DIR) |=> $stable(dir_q));
endmodule

// File: tb/amgpio_top_tb.sv
`timescale 1ns/1ps
module amgpio_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, alt_sel;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  amgpio_top u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [9:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each returned read word with the queued expectation
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R1: unexpected read data %08h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  localparam logic [7:0] ID_TBL [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                                         8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // reset state
    check("R2 reset pin_out", {24'd0, pin_out}, 32'h0);
    check("R2 reset pin_oe", {24'd0, pin_oe}, 32'h0);
    check("R7 reset alt_sel", {24'd0, alt_sel}, 32'h0);
    check("R11 reset irq", {31'd0, irq}, 32'h0);
    bus_read(10'h148, 32'h1, "R5 reset locked");
    bus_read(10'h149, 32'hFF, "R6 reset commit");
    bus_read(10'h104, 32'h0, "R4 reset mask");

    // R4 configuration registers
    bus_write(10'h100, 32'hF0);
    bus_read(10'h100, 32'hF0, "R4 direction");
    for (int k = 0; k < 8; k++) bus_write(10'h140 + 10'(k), 32'(8'h11 * (k + 1)));
    for (int k = 0; k < 8; k++) bus_read(10'h140 + 10'(k), 32'(8'h11 * (k + 1)), "R4 pad byte");
    check("R2 pin_oe follows direction", {24'd0, pin_oe}, 32'hF0);

    // R2 masked data writes
    bus_write(10'h0FF, 32'hAA);
    check("R2 write all-mask", {24'd0, pin_out}, 32'hA0);
    bus_write(10'h030, 32'h00);
    check("R2 partial mask", {24'd0, pin_out}, 32'h80);

    // R3 / R1 inputs and masked reads
    @(negedge clk); pin_in = 8'h05;
    settle(2);
    bus_read(10'h0FF, 32'h85, "R3 mixed data view");
    bus_read(10'h00F, 32'h05, "R1 low mask read");
    bus_read(10'h0C0, 32'h80, "R1 high mask read");

    // R12 unmapped
    bus_read(10'h3F0, 32'h0, "R12 unmapped read");
    bus_write(10'h10A, 32'h3C);
    bus_read(10'h10A, 32'h0, "R12 unmapped read after write");
    bus_read(10'h100, 32'hF0, "R12 write ignored");

    // R8 identification
    for (int k = 0; k < 12; k++) bus_read(10'h3F4 + 10'(k), {24'd0, ID_TBL[k]}, "R8 id byte");

    // R5 R6 R7 lock / commit / alternate function
    bus_write(10'h108, 32'hFF);
    check("R7 alt full commit", {24'd0, alt_sel}, 32'hFF);
    bus_write(10'h149, 32'h0F);
    bus_read(10'h149, 32'hFF, "R6 commit locked");
    bus_write(10'h148, 32'h0ACCE551);
    bus_read(10'h148, 32'h0, "R5 unlocked");
    bus_write(10'h149, 32'h0F);
    bus_read(10'h149, 32'h0F, "R6 commit unlocked");
    bus_write(10'h148, 32'h00001234);
    bus_read(10'h148, 32'h1, "R5 relocked");
    bus_write(10'h108, 32'h00);
    check("R7 alt partial commit", {24'd0, alt_sel}, 32'hF0);
    bus_read(10'h108, 32'hF0, "R7 alt readback");
    bus_write(10'h149, 32'h00);
    bus_read(10'h149, 32'h0F, "R6 commit relocked");

    // interrupts: all inputs, quiet pins, clear leftovers
    bus_write(10'h100, 32'h00);
    @(negedge clk); pin_in = 8'h00;
    settle(4);
    bus_write(10'h103, 32'h05);
    bus_write(10'h107, 32'hFF);
    bus_read(10'h105, 32'h0, "R10 cleared");
    bus_write(10'h104, 32'h01);

    // R9/R11 rising edge on pin 0 and exact irq latency
    @(negedge clk); pin_in = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 irq not before 4th edge", {31'd0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 irq at 4th edge", {31'd0, irq}, 32'h1);
    bus_read(10'h105, 32'h01, "R9 rising edge raw");
    bus_read(10'h106, 32'h01, "R11 masked status");
    bus_write(10'h107, 32'h01);
    bus_read(10'h105, 32'h0, "R10 clear by write");
    check("R11 irq drops", {31'd0, irq}, 32'h0);
    @(negedge clk); pin_in = 8'h00;
    settle(5);
    bus_read(10'h105, 32'h0, "R9 falling ignored when rising chosen");

    // R9 both edges on pin 1
    bus_write(10'h102, 32'h02);
    @(negedge clk); pin_in = 8'h02;
    settle(5);
    bus_read(10'h105, 32'h02, "R9 both edges rise");
    bus_write(10'h107, 32'h02);
    @(negedge clk); pin_in = 8'h00;
    settle(5);
    bus_read(10'h105, 32'h02, "R9 both edges fall");
    bus_write(10'h107, 32'h02);

    // R9/R10 high level on pin 2
    bus_write(10'h101, 32'h04);
    @(negedge clk); pin_in = 8'h04;
    settle(5);
    bus_read(10'h105, 32'h04, "R9 level set");
    bus_write(10'h107, 32'h04);
    bus_read(10'h105, 32'h04, "R10 level wins over clear");
    bus_write(10'h104, 32'h02);
    bus_read(10'h106, 32'h0, "R11 masked off");
    settle(2);
    check("R11 irq masked", {31'd0, irq}, 32'h0);
    @(negedge clk); pin_in = 8'h00;
    settle(5);
    bus_write(10'h107, 32'h04);
    bus_read(10'h105, 32'h0, "R9 level gone");

    settle(3);
    if (exp_q.size() != 0) check("R1 pending reads", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule